// File: doc/BRIEF.md
# Interrupt Status Context Stack

This block keeps the arithmetic status register and the mode register of a processor core together with five saved copies of that pair. When the core dispatches an interrupt from one of a small set of sources, the live pair is pushed so that the service routine can change status and mode bits freely. A return from interrupt, or a jump that clears the current interrupt for reuse, pops the pair back. Software can also push and pop explicitly. Every other interrupt source leaves the stack alone, and software must save whatever it needs for those sources itself.

The live registers are the top of the stack. Ordinary reads and writes of status and mode change only the live pair and never the stack level. Four external flag bits inside the status register follow their input pins at all times. They are never saved or restored, so their values carry through pushes and pops unchanged. A push with no free level sets a sticky overflow flag and is dropped. A pop with nothing saved sets a sticky empty-error flag and leaves the registers as they are.

Top module: `ctx_stack`

## Requirements
- R1: While reset is asserted, statRd and modeRd read zero, and overflow and emptyErr are low.
- R2: A dispatch (dispatchVld high) pushes the live pair only when dispatchSrc is 4, 5 or 6 (external lines), 7 (timer) or 12 (vector interrupt), which is a push mask of 32'h0000_10F0. Dispatch of any other ID leaves the stack level and all registers unchanged.
- R3: A pop request comes from rtiStb, clrJmpStb or popCmd. It reloads the live status (all bits except the flag field) and the live mode from the most recently saved level, and the result is visible on statRd and modeRd one cycle later.
- R4: pushCmd, or a qualifying dispatch, copies the live pair into the next free level and leaves the live registers unchanged.
- R5: The stack holds 5 saved levels. A push request while all 5 are in use is discarded, leaves the saved contents intact and sets overflow, which stays high until reset.
- R6: A pop request with no saved level leaves statRd and modeRd unchanged and sets emptyErr, which stays high until reset.
- R7: Bits [22:19] of statRd equal flagIn as it was sampled at the previous clock edge. Writes to those bits are ignored, and a pop does not restore them.
- R8: statWrEn/modeWrEn write only the live register and never move the stack level. A write in the same cycle as a pop or push takes priority for the live value, and a push in that cycle saves the value from before the write.
- R9: When a push request and a pop request arrive in the same cycle, the pop is handled first and then the push. With levels saved, the level count stays the same and the live pair takes the popped value. With none saved, emptyErr is set and the unchanged live pair is pushed.
- R10: Several pop sources in one cycle make a single pop, and a push command together with a qualifying dispatch makes a single push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispatchVld | input | 1 | Interrupt dispatch strobe |
| dispatchSrc | input | 5 | ID of the dispatched interrupt source |
| rtiStb | input | 1 | Return-from-interrupt strobe |
| clrJmpStb | input | 1 | Clear-current-interrupt jump strobe |
| pushCmd | input | 1 | Explicit push command |
| popCmd | input | 1 | Explicit pop command |
| statWrEn | input | 1 | Write enable of the live status register |
| statWrData | input | 32 | Status write data |
| modeWrEn | input | 1 | Write enable of the live mode register |
| modeWrData | input | 32 | Mode write data |
| flagIn | input | 4 | External flag pins |
| statRd | output | 32 | Live status register with flag field |
| modeRd | output | 32 | Live mode register |
| overflow | output | 1 | Sticky: a push found the stack full |
| emptyErr | output | 1 | Sticky: a pop found nothing saved |

## Verification
The hardest cases to reach are pushes and pops that collide in one cycle at the two ends of the stack, and a write that lands in the same cycle. To get there, the stimulus first fills the stack to exact levels with explicit pushes of distinct values. It then fires combined push, pop and write strobes at level zero, in the middle and at full depth. Every one of the 32 source IDs is dispatched and then returned from, so the push mask is covered completely. The flag pins change on every cycle, which shows that they pass through whatever the stack does.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;
  parameter int CTX_DEPTH = 5;
  localparam int IDX_W = $clog2(CTX_DEPTH + 1);

  typedef struct packed {
    logic             popOk;
    logic             pushOk;
    logic [IDX_W-1:0] popIdx;
    logic [IDX_W-1:0] pushIdx;
  } ctx_strobe_t;
endpackage

// File: rtl/ctx_stack_ctrl.sv
module ctx_stack_ctrl
  import ctx_stack_pkg::*;
#(
  parameter int DEPTH = CTX_DEPTH,
  parameter int SRC_W = 5,
  parameter logic [(1<<SRC_W)-1:0] PUSH_MASK = 32'h0000_10F0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispatchVld,
  input  logic [SRC_W-1:0] dispatchSrc,
  input  logic             rtiStb,
  input  logic             clrJmpStb,
  input  logic             pushCmd,
  input  logic             popCmd,
  output ctx_strobe_t      strb,
  output logic [IDX_W-1:0] level,
  output logic             overflow,
  output logic             emptyErr
);
  logic             pushReq;
  logic             popReq;
  logic [IDX_W-1:0] afterPop;

  always_comb begin
    pushReq      = pushCmd | (dispatchVld & PUSH_MASK[dispatchSrc]);
    popReq       = rtiStb | clrJmpStb | popCmd;
    strb.popOk   = popReq && (level != '0);
    strb.popIdx  = level - IDX_W'(1);
    afterPop     = strb.popOk ? strb.popIdx : level;
    strb.pushOk  = pushReq && (afterPop != IDX_W'(DEPTH));
    strb.pushIdx = afterPop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level    <= '0;
      overflow <= 1'b0;
      emptyErr <= 1'b0;
    end else begin
      level    <= strb.pushOk ? afterPop + IDX_W'(1) : afterPop;
      overflow <= overflow | (pushReq & ~strb.pushOk);
      emptyErr <= emptyErr | (popReq & ~strb.popOk);
    end
  end
endmodule

// File: rtl/ctx_stack_dp.sv
module ctx_stack_dp
  import ctx_stack_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int DEPTH    = CTX_DEPTH,
  parameter int FLAG_LSB = 19,
  parameter int FLAG_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctx_strobe_t       strb,
  input  logic              statWrEn,
  input  logic [DATA_W-1:0] statWrData,
  input  logic              modeWrEn,
  input  logic [DATA_W-1:0] modeWrData,
  input  logic [FLAG_W-1:0] flagIn,
  output logic [DATA_W-1:0] statRd,
  output logic [DATA_W-1:0] modeRd
);
  localparam logic [DATA_W-1:0] FLAG_MASK =
    {{(DATA_W-FLAG_W){1'b0}}, {FLAG_W{1'b1}}} << FLAG_LSB;

  logic [DATA_W-1:0] savedStat [DEPTH];
  logic [DATA_W-1:0] savedMode [DEPTH];
  logic [DATA_W-1:0] liveStat, liveMode;
  logic [FLAG_W-1:0] flagReg;
  logic [DATA_W-1:0] midStat, midMode;
  logic [DEPTH-1:0]  lvlHit;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_hit
      assign lvlHit[g] = strb.pushOk && (strb.pushIdx == IDX_W'(g));
    end
  endgenerate

  always_comb begin
    midStat = liveStat;
    midMode = liveMode;
    for (int i = 0; i < DEPTH; i++) begin
      if (strb.popOk && strb.popIdx == IDX_W'(i)) begin
        midStat = savedStat[i];
        midMode = savedMode[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        savedStat[i] <= '0;
        savedMode[i] <= '0;
      end
      liveStat <= '0;
      liveMode <= '0;
      flagReg  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (lvlHit[i]) begin
          savedStat[i] <= midStat & ~FLAG_MASK;
          savedMode[i] <= midMode;
        end
      end
      liveStat <= (statWrEn ? statWrData : midStat) & ~FLAG_MASK;
      liveMode <= modeWrEn ? modeWrData : midMode;
      flagReg  <= flagIn;
    end
  end

  always_comb begin
    statRd = liveStat | (DATA_W'(flagReg) << FLAG_LSB);
    modeRd = liveMode;
  end
endmodule

// File: rtl/ctx_stack.sv
module ctx_stack
  import ctx_stack_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SRC_W    = 5,
  parameter int FLAG_LSB = 19,
  parameter int FLAG_W   = 4,
  parameter logic [(1<<SRC_W)-1:0] PUSH_MASK = 32'h0000_10F0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dispatchVld,
  input  logic [SRC_W-1:0]  dispatchSrc,
  input  logic              rtiStb,
  input  logic              clrJmpStb,
  input  logic              pushCmd,
  input  logic              popCmd,
  input  logic              statWrEn,
  input  logic [DATA_W-1:0] statWrData,
  input  logic              modeWrEn,
  input  logic [DATA_W-1:0] modeWrData,
  input  logic [FLAG_W-1:0] flagIn,
  output logic [DATA_W-1:0] statRd,
  output logic [DATA_W-1:0] modeRd,
  output logic              overflow,
  output logic              emptyErr
);
  ctx_strobe_t      strb;
  logic [IDX_W-1:0] level;

  ctx_stack_ctrl #(
    .DEPTH(CTX_DEPTH), .SRC_W(SRC_W), .PUSH_MASK(PUSH_MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .dispatchVld(dispatchVld),
    .dispatchSrc(dispatchSrc), .rtiStb(rtiStb), .clrJmpStb(clrJmpStb),
    .pushCmd(pushCmd), .popCmd(popCmd), .strb(strb), .level(level),
    .overflow(overflow), .emptyErr(emptyErr)
  );

  ctx_stack_dp #(
    .DATA_W(DATA_W), .DEPTH(CTX_DEPTH), .FLAG_LSB(FLAG_LSB), .FLAG_W(FLAG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .statWrEn(statWrEn),
    .statWrData(statWrData), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .flagIn(flagIn), .statRd(statRd), .modeRd(modeRd)
  );
endmodule

// File: rtl/ctx_stack_chk.sv
module ctx_stack_chk
  import ctx_stack_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             dispatchVld,
  input logic [4:0]       dispatchSrc,
  input logic             rtiStb,
  input logic             clrJmpStb,
  input logic             pushCmd,
  input logic             popCmd,
  input logic             statWrEn,
  input logic             modeWrEn,
  input logic [3:0]       flagIn,
  input logic [31:0]      statRd,
  input logic [31:0]      modeRd,
  input logic             overflow,
  input logic             emptyErr,
  input logic [IDX_W-1:0] level
);
  localparam logic [31:0] MASK = 32'h0000_10F0;
  logic anyPop, anyPush, anyDisp;
  assign anyPop  = rtiStb | clrJmpStb | popCmd;
  assign anyPush = pushCmd | (dispatchVld & MASK[dispatchSrc]);
  assign anyDisp = anyPop | anyPush;

  // R5
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  // R6
  empty_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    emptyErr |=> emptyErr);
  // R7
  flag_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> statRd[22:19] == $past(flagIn));
  // R8
  write_keeps_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWrEn | modeWrEn) && !anyDisp |=> $stable(level));
  // R2
  nopush_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispatchVld && !MASK[dispatchSrc] && !anyDisp && !modeWrEn
    |=> $stable(level) && $stable(modeRd));
  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyPop && !anyPush && level == '0 && !modeWrEn
    |=> emptyErr && $stable(modeRd) && level == '0);
  // R9
  both_keep_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyPop && anyPush && level != '0 |=> $stable(level));
  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= IDX_W'(CTX_DEPTH));
endmodule

bind ctx_stack ctx_stack_chk u_chk (
  .clk(clk), .rstN(rstN), .dispatchVld(dispatchVld),
  .dispatchSrc(dispatchSrc), .rtiStb(rtiStb), .clrJmpStb(clrJmpStb),
  .pushCmd(pushCmd), .popCmd(popCmd), .statWrEn(statWrEn),
  .modeWrEn(modeWrEn), .flagIn(flagIn), .statRd(statRd), .modeRd(modeRd),
  .overflow(overflow), .emptyErr(emptyErr), .level(level)
);

// File: tb/ctx_stack_bench.sv
`timescale 1ns/1ps
module ctx_stack_bench;
  localparam logic [31:0] MASK  = 32'h0000_10F0;
  localparam logic [31:0] FMASK = 32'h0078_0000;
  localparam int DEPTH = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dispatchVld = 0, rtiStb = 0, clrJmpStb = 0, pushCmd = 0, popCmd = 0;
  logic [4:0] dispatchSrc = '0;
  logic statWrEn = 0, modeWrEn = 0;
  logic [31:0] statWrData = '0, modeWrData = '0;
  logic [3:0] flagIn = '0;
  logic [31:0] statRd, modeRd;
  logic overflow, emptyErr;

  int checks = 0, fails = 0;
  logic [31:0] mS [DEPTH];
  logic [31:0] mM [DEPTH];
  int msp;
  logic [31:0] lS, lM;
  logic [3:0] fl;
  logic ovf, emp;
  logic [7:0] fc = 8'h5;

  always #4 clk = ~clk;

  ctx_stack u_ctx_stack (
    .clk(clk), .rstN(rstN), .dispatchVld(dispatchVld),
    .dispatchSrc(dispatchSrc), .rtiStb(rtiStb), .clrJmpStb(clrJmpStb),
    .pushCmd(pushCmd), .popCmd(popCmd), .statWrEn(statWrEn),
    .statWrData(statWrData), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .flagIn(flagIn), .statRd(statRd), .modeRd(modeRd),
    .overflow(overflow), .emptyErr(emptyErr)
  );

  task automatic check(input string req);
    logic [31:0] eS;
    eS = lS | ({28'd0, fl} << 19);
    checks++;
    if (statRd !== eS || modeRd !== lM || overflow !== ovf || emptyErr !== emp) begin
      fails++;
      $display("FAIL %s: stat=%h mode=%h ovf=%b emp=%b expected stat=%h mode=%h ovf=%b emp=%b",
               req, statRd, modeRd, overflow, emptyErr, eS, lM, ovf, emp);
    end
  endtask

  task automatic tick(input string req);
    logic pu, po;
    logic [31:0] nS, nM;
    fc = fc * 8'd5 + 8'd3;
    flagIn = fc[6:3];
    pu = pushCmd | (dispatchVld & MASK[dispatchSrc]);
    po = rtiStb | clrJmpStb | popCmd;
    nS = lS; nM = lM;
    if (po) begin
      if (msp > 0) begin msp--; nS = mS[msp]; nM = mM[msp]; end
      else emp = 1'b1;
    end
    if (pu) begin
      if (msp < DEPTH) begin mS[msp] = nS; mM[msp] = nM; msp++; end
      else ovf = 1'b1;
    end
    if (statWrEn) nS = statWrData;
    if (modeWrEn) nM = modeWrData;
    @(posedge clk);
    @(negedge clk);
    lS = nS & ~FMASK; lM = nM; fl = flagIn;
    dispatchVld = 0; rtiStb = 0; clrJmpStb = 0; pushCmd = 0; popCmd = 0;
    statWrEn = 0; modeWrEn = 0;
    check(req);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    @(posedge clk); @(negedge clk);
    msp = 0; lS = '0; lM = '0; fl = '0; ovf = 0; emp = 0;
    check("R1");
    rstN = 1;
  endtask

  task automatic wr(input logic [31:0] s, input logic [31:0] m, input string req);
    statWrEn = 1; statWrData = s; modeWrEn = 1; modeWrData = m;
    tick(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    // R2 / R3: sweep every source ID through dispatch and return
    for (int s = 0; s < 32; s++) begin
      doReset();
      wr(32'hFFFF_FFFF ^ s, 32'hA000_0000 | s, "R7");
      dispatchVld = 1; dispatchSrc = 5'(s);
      tick("R2");
      wr(32'h1234_0000 + s, 32'h0BAD_0000 + s, "R8");
      rtiStb = 1;
      tick(MASK[s] ? "R3" : "R6");
    end
    // R4 / R5: fill beyond depth, then drain with all pop sources
    doReset();
    for (int k = 0; k < 7; k++) begin
      wr(32'h0101_0101 * (k + 1), 32'h1111_1111 * (k + 1), "R8");
      pushCmd = 1;
      tick(k < DEPTH ? "R4" : "R5");
    end
    for (int k = 0; k < 7; k++) begin
      case (k % 3)
        0: rtiStb = 1;
        1: clrJmpStb = 1;
        default: popCmd = 1;
      endcase
      tick(k < DEPTH ? "R3" : "R6");
    end
    // R9: collisions at empty, middle and full, with writes in the same cycle
    doReset();
    wr(32'h0000_00AA, 32'h0000_00BB, "R8");
    pushCmd = 1; popCmd = 1;
    tick("R9");
    for (int k = 0; k < 3; k++) begin
      wr(32'h00C0_0000 + k, 32'h00D0_0000 + k, "R8");
      pushCmd = 1;
      tick("R4");
    end
    dispatchVld = 1; dispatchSrc = 5'd12; rtiStb = 1;
    tick("R9");
    pushCmd = 1; clrJmpStb = 1; statWrEn = 1; statWrData = 32'hFEED_0001;
    tick("R9");
    pushCmd = 1; tick("R4");
    pushCmd = 1; tick("R4");
    pushCmd = 1; popCmd = 1; modeWrEn = 1; modeWrData = 32'h7777_0000;
    tick("R9");
    // R8: write together with push, then restore the pre-write value
    doReset();
    wr(32'h0000_5555, 32'h0000_6666, "R8");
    pushCmd = 1; statWrEn = 1; statWrData = 32'h0000_9999;
    modeWrEn = 1; modeWrData = 32'h0000_8888;
    tick("R8");
    popCmd = 1; tick("R8");
    // R10: merged push sources and merged pop sources
    doReset();
    pushCmd = 1; dispatchVld = 1; dispatchSrc = 5'd7;
    tick("R10");
    wr(32'h0, 32'h0, "R8");
    pushCmd = 1; tick("R4");
    rtiStb = 1; clrJmpStb = 1; popCmd = 1;
    tick("R10");
    popCmd = 1; tick("R10");
    rtiStb = 1; tick("R6");
    // R7: flag pins alone over idle cycles
    for (int k = 0; k < 8; k++) tick("R7");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule